// File: doc/BRIEF.md
# Hashed-Index Two-Way Translation Buffer

This block is a small two-way set-associative translation buffer. It caches mappings from a virtual page number and a process identifier to a physical frame number. The set that holds a mapping is chosen by an index function selected at run time, not fixed to the raw low bits of the page number. When the index is the raw low bits, page sequences whose stride is a multiple of the set count all land in a single set and evict each other. The other index functions fold high page bits, bit-reversed high page bits or process identifier bits into the index, so the same traffic spreads over many sets.

A lookup is combinational from registered storage. A refill is written at the clock edge. The translation is reported only on an exact match of page number and process identifier, so the hash choice affects placement and never correctness. Changing the index function empties the buffer, because existing entries would otherwise sit in sets the new function never probes. A separate flush input does the same on request.

Top module: `hashed_tlb`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses: `lk_hit` is 0 and `lk_pfn` is 0.
- R2: `lk_hit` is 1 only when `lk_req` is 1 and a valid entry in the probed set matches both `lk_vpn` and `lk_pid` exactly. On any miss, `lk_pfn` is 0.
- R3: With `hash_mode` = 0, the set index is `vpn[4:0]`.
- R4: With `hash_mode` = 1, the set index is `vpn[4:0] ^ vpn[19:15]`.
- R5: With `hash_mode` = 2, index bit i is `vpn[i] ^ vpn[19-i]` for i = 0..4. This is the high field bit-reversed before the XOR.
- R6: With `hash_mode` = 3, the set index is `vpn[4:0] ^ pid[4:0]`.
- R7: With `fold_en` = 1, index bit 4 is replaced by `vpn[19]`. User-half and supervisor-half pages therefore never share a set.
- R8: Each set has two ways. A refill goes to an invalid way if there is one, otherwise to the least recently used way. A refill and a lookup hit both make the touched entry the most recent.
- R9: A refill whose page number and process identifier already exist in the target set overwrites that entry's frame number and creates no second copy.
- R10: `flush` = 1 at a clock edge invalidates every entry, and any refill requested in that cycle is dropped.
- R11: A change of `hash_mode` or `fold_en` from the previous cycle invalidates every entry at that edge, and a refill in that cycle is dropped.
- R12: A refill accepted at one edge is visible to a lookup in the following cycle, with the refilled frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hash_mode | input | 2 | Index function select (0 raw, 1 high XOR, 2 reversed high XOR, 3 process XOR) |
| fold_en | input | 1 | Replace the index MSB with the page number MSB |
| flush | input | 1 | Invalidate all entries at the edge |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 18 | Translated frame number, 0 on miss |
| rf_en | input | 1 | Refill write enable |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pid | input | 8 | Refill process identifier |
| rf_pfn | input | 18 | Refill frame number |

## Verification
The hardest behaviour to reach from the ports is the index function itself. It is never visible directly, so a wrong index only shows up as the wrong entry being evicted. The stimulus places four pages that one index function maps to a single set and another maps to distinct sets, then cycles through them for several rounds, refilling on every miss. The result is all misses in one mode and only first-round misses in the other. A reference model checks the hit and frame number on every cycle, and the hit total per mode is compared with the value the requirements predict.

// File: rtl/hashed_tlb.sv
module hashed_tlb #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PFN_W = 18,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       hash_mode,
  input  logic             fold_en,
  input  logic             flush,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             rf_en,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PID_W-1:0] rf_pid,
  input  logic [PFN_W-1:0] rf_pfn
);
  localparam int SETS = 1 << IDX_W;

  logic             ent_v   [SETS][2];
  logic [VPN_W-1:0] ent_vpn [SETS][2];
  logic [PID_W-1:0] ent_pid [SETS][2];
  logic [PFN_W-1:0] ent_pfn [SETS][2];
  logic             lru     [SETS];
  logic [2:0]       cfg_q;

  function automatic logic [IDX_W-1:0] set_of(input logic [VPN_W-1:0] vpn,
                                              input logic [PID_W-1:0] pid,
                                              input logic [1:0] mode,
                                              input logic fold);
    logic [IDX_W-1:0] lo, hi, rev, s;
    lo = vpn[IDX_W-1:0];
    hi = vpn[VPN_W-1 -: IDX_W];
    for (int i = 0; i < IDX_W; i++) rev[i] = hi[IDX_W-1-i];
    case (mode)
      2'd0:    s = lo;
      2'd1:    s = lo ^ hi;
      2'd2:    s = lo ^ rev;
      default: s = lo ^ pid[IDX_W-1:0];
    endcase
    if (fold) s[IDX_W-1] = vpn[VPN_W-1];
    return s;
  endfunction

  wire [IDX_W-1:0] lk_set = set_of(lk_vpn, lk_pid, hash_mode, fold_en);
  wire [IDX_W-1:0] rf_set = set_of(rf_vpn, rf_pid, hash_mode, fold_en);
  wire             wipe   = flush || ({hash_mode, fold_en} != cfg_q);

  logic [1:0] lk_m, rf_m;
  always_comb
    for (int w = 0; w < 2; w++) begin
      lk_m[w] = ent_v[lk_set][w] && ent_vpn[lk_set][w] == lk_vpn && ent_pid[lk_set][w] == lk_pid;
      rf_m[w] = ent_v[rf_set][w] && ent_vpn[rf_set][w] == rf_vpn && ent_pid[rf_set][w] == rf_pid;
    end

  wire hit_way = lk_m[1];
  assign lk_hit = lk_req && |lk_m;
  assign lk_pfn = lk_hit ? ent_pfn[lk_set][hit_way] : '0;

  logic victim;
  always_comb
    if (|rf_m)                  victim = rf_m[1];
    else if (!ent_v[rf_set][0]) victim = 1'b0;
    else if (!ent_v[rf_set][1]) victim = 1'b1;
    else                        victim = lru[rf_set];

  always_ff @(posedge clk) begin
    cfg_q <= {hash_mode, fold_en};
    if (!rst_n || wipe) begin
      for (int s = 0; s < SETS; s++) begin
        ent_v[s][0] <= 1'b0;
        ent_v[s][1] <= 1'b0;
        if (!rst_n) lru[s] <= 1'b0;
      end
    end else begin
      if (lk_hit) lru[lk_set] <= ~hit_way;
      if (rf_en) begin
        ent_v[rf_set][victim]   <= 1'b1;
        ent_vpn[rf_set][victim] <= rf_vpn;
        ent_pid[rf_set][victim] <= rf_pid;
        ent_pfn[rf_set][victim] <= rf_pfn;
        lru[rf_set]             <= ~victim;
      end
    end
  end
endmodule

module hashed_tlb_chk #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PFN_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       hash_mode,
  input logic             fold_en,
  input logic             flush,
  input logic             lk_req,
  input logic [VPN_W-1:0] lk_vpn,
  input logic [PID_W-1:0] lk_pid,
  input logic             lk_hit,
  input logic [PFN_W-1:0] lk_pfn,
  input logic             rf_en,
  input logic [VPN_W-1:0] rf_vpn,
  input logic [PID_W-1:0] rf_pid,
  input logic [PFN_W-1:0] rf_pfn
);
  assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_req);

  assert_miss_zero_pfn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_pfn == '0);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  assert_cfg_change_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && {hash_mode, fold_en} != $past({hash_mode, fold_en})) |=> !lk_hit);

  assert_refill_visible_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && $past(rst_n) && $past(rf_en) && !$past(flush)
     && {hash_mode, fold_en} == $past({hash_mode, fold_en})
     && $past({hash_mode, fold_en}) == $past({hash_mode, fold_en}, 2)
     && lk_vpn == $past(rf_vpn) && lk_pid == $past(rf_pid))
    |-> (lk_hit && lk_pfn == $past(rf_pfn)));
endmodule

bind hashed_tlb hashed_tlb_chk u_chk (.*);

// File: tb/sim_hashed_tlb.sv
`timescale 1ns/1ps
module sim_hashed_tlb;
  typedef struct packed { logic [19:0] vpn; logic [7:0] pid; logic [17:0] pfn; } ent_t;

  logic clk = 0, rst_n = 0;
  logic [1:0] hash_mode = 0;
  logic fold_en = 0, flush = 0, lk_req = 0, rf_en = 0;
  logic [19:0] lk_vpn = 0, rf_vpn = 0;
  logic [7:0] lk_pid = 0, rf_pid = 0;
  logic [17:0] rf_pfn = 0;
  logic lk_hit;
  logic [17:0] lk_pfn;

  int checks = 0, errors = 0;
  string tag = "R1";
  ent_t mq[32][$];
  logic [2:0] pcfg = 0;
  logic g_hit;

  always #2 clk = ~clk;

  hashed_tlb u0 (.*);

  function automatic int midx(logic [19:0] v, logic [7:0] p);
    int s = 0;
    for (int i = 0; i < 5; i++) begin
      case (hash_mode)
        2'd0: s[i] = v[i];
        2'd1: s[i] = v[i] ^ v[15+i];
        2'd2: s[i] = v[i] ^ v[19-i];
        default: s[i] = v[i] ^ p[i];
      endcase
    end
    if (fold_en) s[4] = v[19];
    return s;
  endfunction

  task automatic chk(bit ok, string t, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic step(bit req, logic [19:0] lv, logic [7:0] lp,
                      bit rf, logic [19:0] rv, logic [7:0] rp, logic [17:0] rpf, bit fl);
    int s, hpos, rs, fpos;
    bit eh;
    logic [17:0] ep;
    ent_t e;
    lk_req = req; lk_vpn = lv; lk_pid = lp;
    rf_en = rf; rf_vpn = rv; rf_pid = rp; rf_pfn = rpf; flush = fl;
    #1;
    s = midx(lv, lp); hpos = -1; eh = 0; ep = 0;
    if (req)
      for (int i = 0; i < mq[s].size(); i++)
        if (mq[s][i].vpn == lv && mq[s][i].pid == lp) begin hpos = i; eh = 1; ep = mq[s][i].pfn; end
    chk(lk_hit == eh && lk_pfn == ep, tag, {lk_hit, lk_pfn}, {eh, ep});
    g_hit = lk_hit;
    @(posedge clk);
    if (fl || {hash_mode, fold_en} != pcfg) begin
      for (int i = 0; i < 32; i++) mq[i].delete();
    end else begin
      if (hpos >= 0) begin e = mq[s][hpos]; mq[s].delete(hpos); mq[s].push_front(e); end
      if (rf) begin
        rs = midx(rv, rp); fpos = -1;
        for (int i = 0; i < mq[rs].size(); i++)
          if (mq[rs][i].vpn == rv && mq[rs][i].pid == rp) fpos = i;
        if (fpos >= 0) mq[rs].delete(fpos);
        else if (mq[rs].size() == 2) void'(mq[rs].pop_back());
        mq[rs].push_front('{vpn: rv, pid: rp, pfn: rpf});
      end
    end
    pcfg = {hash_mode, fold_en};
    @(negedge clk);
  endtask

  task automatic look(logic [19:0] v, logic [7:0] p);
    step(1, v, p, 0, 0, 0, 0, 0);
  endtask
  task automatic fill(logic [19:0] v, logic [7:0] p, logic [17:0] f);
    step(0, 0, 0, 1, v, p, f, 0);
  endtask

  task automatic set_cfg(logic [1:0] m, bit f);
    hash_mode = m; fold_en = f;
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic stride(logic [19:0] v[4], logic [7:0] p[4], output int hits);
    hits = 0;
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        look(v[k], p[k]);
        if (g_hit) hits++;
        else fill(v[k], p[k], 18'(v[k] + 20'(p[k]) + 20'h100));
      end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] sv[4], pv[4], fv[4];
    logic [7:0] zp[4], ip[4];
    int h;
    for (int k = 0; k < 4; k++) begin
      sv[k] = 20'(k) << 15; pv[k] = 20'h00040;
      zp[k] = 0; ip[k] = 8'(k);
    end
    fv[0] = 20'h00003; fv[1] = 20'h80003; fv[2] = 20'h00023; fv[3] = 20'h80023;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    look(20'h00005, 8'h01);
    chk(lk_hit == 0 && lk_pfn == 0, "R1 reset miss", lk_hit, 0);

    tag = "R12";
    fill(20'h00005, 8'h01, 18'h111);
    look(20'h00005, 8'h01);
    chk(g_hit == 1 && lk_pfn == 18'h111, "R12 refill visible", lk_pfn, 18'h111);

    tag = "R2";
    look(20'h00005, 8'h02);
    chk(g_hit == 0, "R2 pid mismatch misses", g_hit, 0);
    step(0, 20'h00005, 8'h01, 0, 0, 0, 0, 0);
    chk(g_hit == 0 && lk_pfn == 0, "R2 no request no hit", lk_pfn, 0);

    tag = "R9";
    fill(20'h00005, 8'h01, 18'h222);
    fill(20'h00025, 8'h01, 18'h333);
    look(20'h00005, 8'h01);
    chk(lk_pfn == 18'h222, "R9 overwrite in place", lk_pfn, 18'h222);
    look(20'h00025, 8'h01);
    chk(g_hit == 1, "R9 no duplicate", g_hit, 1);

    tag = "R8";
    fill(20'h00007, 0, 18'h0a);
    fill(20'h00027, 0, 18'h0b);
    look(20'h00007, 0);
    fill(20'h00047, 0, 18'h0c);
    look(20'h00027, 0);
    chk(g_hit == 0, "R8 LRU way evicted", g_hit, 0);
    look(20'h00007, 0);
    chk(g_hit == 1, "R8 recent way kept", g_hit, 1);

    tag = "R10";
    step(0, 0, 0, 1, 20'h00009, 0, 18'h5, 1);
    look(20'h00009, 0);
    chk(g_hit == 0, "R10 refill dropped on flush", g_hit, 0);
    look(20'h00007, 0);
    chk(g_hit == 0, "R10 old entry gone", g_hit, 0);

    tag = "R11";
    fill(20'h00005, 0, 18'h44);
    hash_mode = 3;
    step(0, 0, 0, 1, 20'h00006, 0, 18'h45, 0);
    look(20'h00005, 0);
    chk(g_hit == 0, "R11 mode change empties", g_hit, 0);
    look(20'h00006, 0);
    chk(g_hit == 0, "R11 refill dropped", g_hit, 0);

    tag = "R3"; set_cfg(0, 0);
    stride(sv, zp, h);
    chk(h == 0, "R3 raw index thrashes", h, 0);
    tag = "R4"; set_cfg(1, 0);
    stride(sv, zp, h);
    chk(h == 12, "R4 high xor spreads", h, 12);
    tag = "R5"; set_cfg(2, 0);
    stride(sv, zp, h);
    chk(h == 12, "R5 reversed xor spreads", h, 12);
    tag = "R3"; set_cfg(0, 0);
    stride(pv, ip, h);
    chk(h == 0, "R3 contexts collide", h, 0);
    tag = "R6"; set_cfg(3, 0);
    stride(pv, ip, h);
    chk(h == 12, "R6 pid xor spreads", h, 12);
    tag = "R3"; set_cfg(0, 0);
    stride(fv, zp, h);
    chk(h == 0, "R3 halves collide", h, 0);
    tag = "R7"; set_cfg(0, 1);
    stride(fv, zp, h);
    chk(h == 12, "R7 fold separates halves", h, 12);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule